// File: doc/BRIEF.md
# DMA FIFO Port Ready and Request Control

This block sits beside one DMA-facing FIFO port of a USB device endpoint buffer. It produces the DMA request line, gated by a DMA enable bit and by whether the buffer can move data in the selected direction. It also produces the buffer-ready flag for the endpoint bound to DMA, together with a level interrupt that follows that flag.

The moment the ready flag rises depends on an interrupt-mode bit and on the buffer direction. With the mode bit at 1, the flag rises on every packet-complete event, as it would for an endpoint that is not bound to DMA. With the mode bit at 0 and a receive (OUT) buffer, the flag waits until the DMA side has drained a short packet. Through that wait the packet's valid flag and its latched length stay put, so software can read the length when the interrupt arrives.

The block also swaps byte lanes on the FIFO data path in both directions when asked. It never swaps in 8-bit bus mode.

Top module: `dma_port_ctrl`

## Requirements
- R1: `dreq` is 1 exactly when `dma_en` is 1 and either `dir_in`=1 with `buf_has_space`=1, or `dir_in`=0 with `buf_has_data`=1. It is combinational, with no cycle of delay.
- R2: When `swap_en`=1 and `byte_mode`=0, bits 15:8 and 7:0 trade places, from `dma_wdata` to `fifo_wdata` and from `fifo_rdata` to `dma_rdata`. When `swap_en`=0, both paths pass the data unchanged: the even address sits on bits 7:0 and the odd address on bits 15:8.
- R3: When `byte_mode`=1, both data paths pass the data unchanged, whatever the value of `swap_en`.
- R4: A `pkt_done` pulse sets `valid` and latches `pkt_len` into `data_len`, both visible one cycle later. `rd_word` and `rd_last` pulses change neither of them.
- R5: A `buf_clr` pulse makes `valid` 0 one cycle later, even if `pkt_done` pulses in the same cycle. `data_len` keeps its value.
- R6: With `int_mode`=1, `ready` is 1 in the cycle after a `pkt_done` pulse, in either direction.
- R7: With `int_mode`=0 and `dir_in`=0, a short packet of nonzero length leaves `ready` at 0 until the `rd_last` pulse, and `ready` is 1 one cycle after that pulse. A packet that is not short never sets `ready`, and an `rd_last` pulse with no short packet outstanding is ignored.
- R8: With `int_mode`=0 and `dir_in`=0, a short packet with `pkt_len`=0 sets `ready` one cycle after its `pkt_done` pulse.
- R9: With `int_mode`=0 and `dir_in`=1, `ready` stays 0 after a `pkt_done` pulse.
- R10: A `buf_clr` pulse clears `ready` one cycle later when `rdy_clr_mode`=0. When `rdy_clr_mode`=1, it leaves `ready` unchanged.
- R11: A `rdy_sw_clr` pulse clears `ready` one cycle later, and it wins over a set event in the same cycle.
- R12: `irq` is the value `ready` had one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | DMA request enable |
| int_mode | input | 1 | 1: ready on each packet; 0: ready after a short packet drains (OUT) or never (IN) |
| swap_en | input | 1 | Byte-lane swap request |
| byte_mode | input | 1 | 8-bit bus mode; disables swapping |
| rdy_clr_mode | input | 1 | 1: buffer clear leaves ready alone |
| dir_in | input | 1 | Buffer direction: 1 = IN (transmit), 0 = OUT (receive) |
| buf_clr | input | 1 | Buffer clear pulse |
| rdy_sw_clr | input | 1 | Software clear of the ready flag |
| pkt_done | input | 1 | Packet complete pulse |
| pkt_short | input | 1 | Qualifies pkt_done as a short packet |
| pkt_len | input | LEN_W | Length of the completed packet |
| rd_word | input | 1 | DMA read of one word |
| rd_last | input | 1 | DMA read of the final word in the buffer |
| buf_has_data | input | 1 | Buffer holds readable data |
| buf_has_space | input | 1 | Buffer has free space |
| dma_wdata | input | DATA_W | Write data from the DMA side |
| fifo_rdata | input | DATA_W | Read data from the buffer |
| fifo_wdata | output | DATA_W | Write data to the buffer |
| dma_rdata | output | DATA_W | Read data to the DMA side |
| dreq | output | 1 | DMA request |
| ready | output | 1 | Buffer-ready flag |
| irq | output | 1 | Buffer-ready interrupt level |
| valid | output | 1 | Latched packet valid |
| data_len | output | LEN_W | Latched packet length |

## Verification
`dreq` and both data paths are combinational, so the bench checks them in the same half-cycle in which it drives the inputs. `ready`, `valid` and `data_len` change at the first rising edge after an event. The bench drives each pulse on a falling edge, moves to the next falling edge and samples there. `irq` is due one edge later, so the bench samples it after a second falling edge. In the R7 case the bench checks at every step of the drain sequence that `ready` stays low until the cycle after the final read.

// File: rtl/dma_port_pkg.sv
package dma_port_pkg;
   typedef enum logic {
      DIR_OUT = 1'b0,
      DIR_IN  = 1'b1
   } buf_dir_e;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/dma_byte_lane.sv
module dma_byte_lane #(
   parameter int unsigned DATA_W = 16
) (
   input  logic              swap,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   import dma_port_pkg::*;
   localparam int unsigned NBYTES = DATA_W / BYTE_W;

   initial begin
      if (DATA_W % BYTE_W != 0 || NBYTES < 2)
         $error("dma_byte_lane: DATA_W must be a multiple of 8 and at least 16");
   end

   logic [DATA_W-1:0] rev;

   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      assign rev[i*BYTE_W +: BYTE_W] = din[(NBYTES-1-i)*BYTE_W +: BYTE_W];
   end

   assign dout = swap ? rev : din;
endmodule

// File: rtl/dma_len_latch.sv
module dma_len_latch #(
   parameter int unsigned LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pkt_done,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             buf_clr,
   output logic             valid,
   output logic [LEN_W-1:0] data_len
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         data_len <= '0;
      end else begin
         if (buf_clr)       valid <= 1'b0;
         else if (pkt_done) valid <= 1'b1;
         if (pkt_done && !buf_clr) data_len <= pkt_len;
      end
   end
endmodule

// File: rtl/dma_rdy_ctrl.sv
module dma_rdy_ctrl
   import dma_port_pkg::*;
#(
   parameter int unsigned LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             int_mode,
   input  buf_dir_e         dir,
   input  logic             rdy_clr_mode,
   input  logic             buf_clr,
   input  logic             rdy_sw_clr,
   input  logic             pkt_done,
   input  logic             pkt_short,
   input  logic [LEN_W-1:0] pkt_len,
   input  logic             rd_last,
   output logic             ready,
   output logic             irq
);
   logic drain_wait;
   logic zlp, short_data, set_rdy, clr_rdy;

   always_comb begin
      zlp        = pkt_done && pkt_short && (pkt_len == '0);
      short_data = pkt_done && pkt_short && (pkt_len != '0);
      if (int_mode)
         set_rdy = pkt_done;
      else if (dir == DIR_OUT)
         set_rdy = zlp || (rd_last && drain_wait);
      else
         set_rdy = 1'b0;
      clr_rdy = rdy_sw_clr || (buf_clr && !rdy_clr_mode);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drain_wait <= 1'b0;
         ready      <= 1'b0;
         irq        <= 1'b0;
      end else begin
         if (buf_clr || (rd_last && drain_wait))
            drain_wait <= 1'b0;
         else if (!int_mode && dir == DIR_OUT && short_data)
            drain_wait <= 1'b1;

         if (clr_rdy)      ready <= 1'b0;
         else if (set_rdy) ready <= 1'b1;

         irq <= ready;
      end
   end
endmodule

// File: rtl/dma_port_ctrl.sv
module dma_port_ctrl
   import dma_port_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LEN_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_en,
   input  logic              int_mode,
   input  logic              swap_en,
   input  logic              byte_mode,
   input  logic              rdy_clr_mode,
   input  logic              dir_in,
   input  logic              buf_clr,
   input  logic              rdy_sw_clr,
   input  logic              pkt_done,
   input  logic              pkt_short,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic              rd_word,
   input  logic              rd_last,
   input  logic              buf_has_data,
   input  logic              buf_has_space,
   input  logic [DATA_W-1:0] dma_wdata,
   input  logic [DATA_W-1:0] fifo_rdata,
   output logic [DATA_W-1:0] fifo_wdata,
   output logic [DATA_W-1:0] dma_rdata,
   output logic              dreq,
   output logic              ready,
   output logic              irq,
   output logic              valid,
   output logic [LEN_W-1:0]  data_len
);
   initial begin
      if (LEN_W < 1) $error("dma_port_ctrl: LEN_W must be at least 1");
   end

   buf_dir_e dir;
   logic     swap_act;
   logic     can_move;
   logic     unused_rd;

   assign dir       = dir_in ? DIR_IN : DIR_OUT;
   assign swap_act  = swap_en && !byte_mode;
   assign can_move  = (dir == DIR_IN) ? buf_has_space : buf_has_data;
   assign dreq      = dma_en && can_move;
   assign unused_rd = rd_word;

   dma_byte_lane #(.DATA_W(DATA_W)) u_wr_lane (
      .swap (swap_act),
      .din  (dma_wdata),
      .dout (fifo_wdata)
   );

   dma_byte_lane #(.DATA_W(DATA_W)) u_rd_lane (
      .swap (swap_act),
      .din  (fifo_rdata),
      .dout (dma_rdata)
   );

   dma_len_latch #(.LEN_W(LEN_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .pkt_done (pkt_done),
      .pkt_len  (pkt_len),
      .buf_clr  (buf_clr),
      .valid    (valid),
      .data_len (data_len)
   );

   dma_rdy_ctrl #(.LEN_W(LEN_W)) u_rdy (
      .clk          (clk),
      .rst_n        (rst_n),
      .int_mode     (int_mode),
      .dir          (dir),
      .rdy_clr_mode (rdy_clr_mode),
      .buf_clr      (buf_clr),
      .rdy_sw_clr   (rdy_sw_clr),
      .pkt_done     (pkt_done),
      .pkt_short    (pkt_short),
      .pkt_len      (pkt_len),
      .rd_last      (rd_last),
      .ready        (ready),
      .irq          (irq)
   );
endmodule

// File: rtl/dma_port_ctrl_chk.sv
module dma_port_ctrl_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LEN_W  = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dma_en,
   input logic              int_mode,
   input logic              byte_mode,
   input logic              rdy_clr_mode,
   input logic              dir_in,
   input logic              buf_clr,
   input logic              rdy_sw_clr,
   input logic              pkt_done,
   input logic              rd_word,
   input logic              rd_last,
   input logic [DATA_W-1:0] fifo_rdata,
   input logic [DATA_W-1:0] dma_rdata,
   input logic              dreq,
   input logic              ready,
   input logic              irq,
   input logic              valid,
   input logic [LEN_W-1:0]  data_len
);
   p_dreq_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_en |-> !dreq);

   p_no_swap_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_mode |-> (dma_rdata == fifo_rdata));

   p_len_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !pkt_done && !buf_clr && (rd_word || rd_last)) |=> ($stable(data_len) && valid));

   p_clr_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
      buf_clr |=> !valid);

   p_in_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_mode && dir_in && !ready) |=> !ready);

   p_clr_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_clr && !rdy_clr_mode) |=> !ready);

   p_sw_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_sw_clr |=> !ready);

   p_irq_lag_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(ready));
endmodule

bind dma_port_ctrl dma_port_ctrl_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .dma_en       (dma_en),
   .int_mode     (int_mode),
   .byte_mode    (byte_mode),
   .rdy_clr_mode (rdy_clr_mode),
   .dir_in       (dir_in),
   .buf_clr      (buf_clr),
   .rdy_sw_clr   (rdy_sw_clr),
   .pkt_done     (pkt_done),
   .rd_word      (rd_word),
   .rd_last      (rd_last),
   .fifo_rdata   (fifo_rdata),
   .dma_rdata    (dma_rdata),
   .dreq         (dreq),
   .ready        (ready),
   .irq          (irq),
   .valid        (valid),
   .data_len     (data_len)
);

// File: tb/tb_dma_port_ctrl.sv
`timescale 1ns/1ps
module tb_dma_port_ctrl;
   localparam int DATA_W = 16;
   localparam int LEN_W  = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dma_en = 0, int_mode = 0, swap_en = 0, byte_mode = 0, rdy_clr_mode = 0, dir_in = 0;
   logic buf_clr = 0, rdy_sw_clr = 0, pkt_done = 0, pkt_short = 0;
   logic rd_word = 0, rd_last = 0, buf_has_data = 0, buf_has_space = 0;
   logic [LEN_W-1:0]  pkt_len = '0;
   logic [DATA_W-1:0] dma_wdata = '0, fifo_rdata = '0;
   logic [DATA_W-1:0] fifo_wdata, dma_rdata;
   logic dreq, ready, irq, valid;
   logic [LEN_W-1:0] data_len;

   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   dma_port_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dut (
      .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .int_mode(int_mode), .swap_en(swap_en),
      .byte_mode(byte_mode), .rdy_clr_mode(rdy_clr_mode), .dir_in(dir_in), .buf_clr(buf_clr),
      .rdy_sw_clr(rdy_sw_clr), .pkt_done(pkt_done), .pkt_short(pkt_short), .pkt_len(pkt_len),
      .rd_word(rd_word), .rd_last(rd_last), .buf_has_data(buf_has_data),
      .buf_has_space(buf_has_space), .dma_wdata(dma_wdata), .fifo_rdata(fifo_rdata),
      .fifo_wdata(fifo_wdata), .dma_rdata(dma_rdata), .dreq(dreq), .ready(ready), .irq(irq),
      .valid(valid), .data_len(data_len)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic pkt(input bit shrt, input int len);
      pkt_done = 1; pkt_short = shrt; pkt_len = LEN_W'(len);
      step();
      pkt_done = 0; pkt_short = 0;
   endtask

   task automatic sw_clear();
      rdy_sw_clr = 1; step(); rdy_sw_clr = 0;
   endtask

   task automatic bclr();
      buf_clr = 1; step(); buf_clr = 0;
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!ready && !irq && !valid && data_len == 0, "reset", {ready, irq, valid}, 0);
      rst_n = 1;
      @(negedge clk);

      // R1: sweep all gating inputs
      for (int k = 0; k < 16; k++) begin
         dma_en = k[0]; dir_in = k[1]; buf_has_data = k[2]; buf_has_space = k[3];
         #0.5;
         check(dreq == (k[0] && (k[1] ? k[3] : k[2])), "R1", dreq, k[0] && (k[1] ? k[3] : k[2]));
      end
      dma_en = 0; dir_in = 0; buf_has_data = 0; buf_has_space = 0;

      // R2 / R3: swap sweep over modes and patterns
      for (int m = 0; m < 4; m++) begin
         for (int p = 0; p < 8; p++) begin
            logic [15:0] w, r, ew, er;
            swap_en = m[0]; byte_mode = m[1];
            w = 16'((p * 16'h3B17) ^ 16'hA5C3);
            r = 16'((p * 16'h1F29) + 16'h0F80);
            dma_wdata = w; fifo_rdata = r;
            #0.5;
            ew = (m == 1) ? {w[7:0], w[15:8]} : w;
            er = (m == 1) ? {r[7:0], r[15:8]} : r;
            if (m[1]) begin
               check(fifo_wdata == w && dma_rdata == r, "R3", dma_rdata, r);
            end else begin
               check(fifo_wdata == ew, "R2", fifo_wdata, ew);
               check(dma_rdata == er, "R2", dma_rdata, er);
            end
         end
      end
      swap_en = 0; byte_mode = 0;

      // R4 / R7: mode 0 OUT, short packet, reads keep length
      int_mode = 0; dir_in = 0;
      pkt(1, 37);
      check(valid && data_len == 37, "R4", data_len, 37);
      check(!ready, "R7", ready, 0);
      for (int i = 0; i < 3; i++) begin
         rd_word = 1; step(); rd_word = 0;
         check(valid && data_len == 37, "R4", data_len, 37);
         check(!ready, "R7", ready, 0);
      end
      rd_last = 1; step(); rd_last = 0;
      check(ready, "R7", ready, 1);
      check(valid && data_len == 37, "R4", data_len, 37);
      check(!irq, "R12", irq, 0);
      step();
      check(irq, "R12", irq, 1);
      // R5: clear, with pkt_done in same cycle
      rdy_clr_mode = 0;
      buf_clr = 1; pkt_done = 1; pkt_len = 11'd9; step(); buf_clr = 0; pkt_done = 0;
      check(!valid, "R5", valid, 0);
      check(data_len == 37, "R5", data_len, 37);
      check(!ready, "R10", ready, 0);
      step();
      check(!irq, "R12", irq, 0);

      // R7: full packet and stray rd_last do nothing
      pkt(0, 64);
      check(!ready, "R7", ready, 0);
      rd_last = 1; step(); rd_last = 0;
      check(!ready, "R7", ready, 0);
      bclr();

      // R8: zero-length short packet
      pkt(1, 0);
      check(ready && valid && data_len == 0, "R8", ready, 1);
      sw_clear();
      check(!ready, "R11", ready, 0);
      bclr();

      // R9: mode 0 IN never sets
      dir_in = 1;
      pkt(1, 0);
      check(!ready, "R9", ready, 0);
      pkt(0, 64);
      check(!ready, "R9", ready, 0);
      rd_last = 1; step(); rd_last = 0;
      check(!ready, "R9", ready, 0);
      bclr();

      // R6: mode 1, both directions
      int_mode = 1;
      for (int d = 0; d < 2; d++) begin
         dir_in = d[0];
         pkt(0, 64);
         check(ready, "R6", ready, 1);
         sw_clear();
         check(!ready, "R11", ready, 0);
         pkt(1, 5);
         check(ready, "R6", ready, 1);
         sw_clear();
      end

      // R10: clear mode 1 keeps ready
      dir_in = 0; rdy_clr_mode = 1;
      pkt(0, 64);
      bclr();
      check(ready && !valid, "R10", ready, 1);
      sw_clear();
      check(!ready, "R10", ready, 0);
      rdy_clr_mode = 0;
      pkt(0, 64);
      bclr();
      check(!ready, "R10", ready, 0);

      // R11: clear beats simultaneous set
      pkt_done = 1; rdy_sw_clr = 1; step(); pkt_done = 0; rdy_sw_clr = 0;
      check(!ready, "R11", ready, 0);
      check(valid, "R4", valid, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end
endmodule